// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block takes a physical address and decides which of eight DRAM rows holds it. Each row has an end boundary register. The register holds the running total of installed memory from row 0 up to that row, counted in 8 MB units. The decoder picks the first row whose end boundary lies above the address. It reports that row as a one-hot select, together with the address minus the row's start.

A row with no memory repeats the boundary of the row before it, so no address can ever fall into it. Two fixed holes can be switched in through a 2-bit field: 512 KB to 640 KB, or 15 MB to 16 MB. An address inside the active hole never reaches DRAM. It is reported as a miss, just like an address at or beyond the top of installed memory.

Addresses enter on a valid/ready stream, and results leave on a valid/ready stream one cycle later. Back-pressure follows three rules:
- The input is accepted in any cycle where `in_valid` and `in_ready` are both high.
- `in_ready` is high while the output register is empty or is being drained in the same cycle.
- While `res_valid` is high and `res_ready` is low, every result field holds steady.

The boundary and hole registers are written through a plain write port. A write changes how addresses accepted from the next cycle on are decoded.

Top module: `row_bound_decoder`

## Requirements
- R1: After reset no result is pending, `in_ready` is high, and every boundary and the hole field are zero, so any address decodes as a miss.
- R2: A write with `cfg_sel` = n (0..7) loads boundary n from `cfg_wdata`. A write with `cfg_sel` = 8 loads the hole field from `cfg_wdata[1:0]`. The new value applies to addresses accepted on later cycles.
- R3: Row n is selected when boundary[n-1]×8 MB ≤ address < boundary[n]×8 MB, with boundary[-1] taken as 0. `res_row` bit n is then the only bit set, and `res_hit` is high.
- R4: A row whose boundary equals the previous row's boundary is never selected. The address is decoded against the later rows instead.
- R5: An address at or above boundary[7]×8 MB gives `res_miss` high, `res_hit` low, `res_row` zero and `res_offset` zero.
- R6: Hole code 01 makes addresses 0x80000 to 0x9FFFF miss. Addresses just outside that range decode normally.
- R7: Hole code 10 makes addresses 0xF00000 to 0xFFFFFF miss. Addresses just outside that range decode normally.
- R8: Hole codes 00 and 11 create no hole.
- R9: For a hit, `res_offset` equals the address minus boundary[n-1]×8 MB of the selected row. Exactly one of `res_hit` and `res_miss` is high on every result.
- R10: A result appears on the cycle after its address is accepted. `in_ready` equals `!res_valid || res_ready`. A stalled result holds all of its fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select: 0..7 boundaries, 8 hole field |
| cfg_wdata | input | 8 | Configuration write data |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Address accepted when high with in_valid |
| in_addr | input | 32 | Physical address |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_row | output | 8 | One-hot selected row, zero on a miss |
| res_offset | output | 32 | Address relative to the row start, zero on a miss |
| res_hit | output | 1 | Address maps to a row |
| res_miss | output | 1 | Address beyond memory or inside the hole |

## Verification
The hardest case to reach from the ports is an address that lands exactly on a boundary shared by several empty rows. The decoder must skip every repeated value and select the first row whose end is strictly greater. Hole edges that overlap row 0 are similarly hard to reach. The stimulus loads directed boundary sets that contain runs of equal values and probes each start, end and end-minus-one address. Random rounds then build monotonic boundary sets in which about a quarter of the rows are empty. They draw addresses aligned to 8 MB multiples of the boundaries and biased toward the two hole windows. A stall sequence holds `res_ready` low while a second address waits, to show that the held result and the queued address both come through intact.

// File: rtl/row_bound_pkg.sv
package row_bound_pkg;
  localparam int ROWS     = 8;
  localparam int BND_W    = 8;
  localparam int ADDR_W   = 32;
  localparam int GRAN_LG2 = 23;

  typedef enum logic [1:0] {
    HOLE_NONE = 2'b00,
    HOLE_LOW  = 2'b01,
    HOLE_HIGH = 2'b10,
    HOLE_RSVD = 2'b11
  } hole_code_t;

  localparam logic [31:0] LOW_HOLE_BASE  = 32'h0008_0000;
  localparam logic [31:0] LOW_HOLE_END   = 32'h000A_0000;
  localparam logic [31:0] HIGH_HOLE_BASE = 32'h00F0_0000;
  localparam logic [31:0] HIGH_HOLE_END  = 32'h0100_0000;
endpackage

// File: rtl/row_bound_cfg.sv
module row_bound_cfg
  import row_bound_pkg::*;
#(
  parameter int N_ROWS = ROWS,
  parameter int BW     = BND_W,
  localparam int SEL_W = $clog2(N_ROWS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [SEL_W-1:0]            sel,
  input  logic [BW-1:0]               wdata,
  output logic [N_ROWS-1:0][BW-1:0]   bnd,
  output hole_code_t                  hole
);
  for (genvar n = 0; n < N_ROWS; n++) begin : g_bnd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        bnd[n] <= '0;
      else if (we && sel == SEL_W'(n))   bnd[n] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hole <= HOLE_NONE;
    else if (we && sel == SEL_W'(N_ROWS))   hole <= hole_code_t'(wdata[1:0]);
  end

  AST_BND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel < SEL_W'(N_ROWS)) |=> (bnd[$past(sel)] == $past(wdata))); // R2
  AST_HOLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_W'(N_ROWS)) |=> (hole == hole_code_t'($past(wdata[1:0])))); // R2
endmodule

// File: rtl/row_bound_match.sv
module row_bound_match
  import row_bound_pkg::*;
#(
  parameter int N_ROWS = ROWS,
  parameter int BW     = BND_W,
  parameter int HI_W   = ADDR_W - GRAN_LG2,
  localparam int CMP_W = (HI_W > BW) ? HI_W : BW
) (
  input  logic [HI_W-1:0]             addr_hi,
  input  logic [N_ROWS-1:0][BW-1:0]   bnd,
  output logic [N_ROWS-1:0]           sel,
  output logic [BW-1:0]               start_units,
  output logic                        found
);
  logic [N_ROWS-1:0] below;
  logic [N_ROWS:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar n = 0; n < N_ROWS; n++) begin : g_cmp
    assign below[n]  = CMP_W'(addr_hi) < CMP_W'(bnd[n]);
    assign seen[n+1] = seen[n] | below[n];
    assign sel[n]    = below[n] & ~seen[n];
  end
  assign found = seen[N_ROWS];

  always_comb begin
    start_units = '0;
    for (int n = 1; n < N_ROWS; n++) begin
      if (sel[n]) start_units = start_units | bnd[n-1];
    end
  end
endmodule

// File: rtl/row_bound_hole.sv
module row_bound_hole
  import row_bound_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  hole_code_t    code,
  output logic          in_hole
);
  always_comb begin
    unique case (code)
      HOLE_LOW:  in_hole = (addr >= AW'(LOW_HOLE_BASE))  && (addr < AW'(LOW_HOLE_END));
      HOLE_HIGH: in_hole = (addr >= AW'(HIGH_HOLE_BASE)) && (addr < AW'(HIGH_HOLE_END));
      default:   in_hole = 1'b0;
    endcase
  end
endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder
  import row_bound_pkg::*;
#(
  parameter int N_ROWS = ROWS,
  parameter int BW     = BND_W,
  parameter int AW     = ADDR_W,
  parameter int GL2    = GRAN_LG2,
  localparam int SEL_W = $clog2(N_ROWS + 1),
  localparam int HI_W  = AW - GL2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [BW-1:0]     cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [N_ROWS-1:0] res_row,
  output logic [AW-1:0]     res_offset,
  output logic              res_hit,
  output logic              res_miss
);
  logic [N_ROWS-1:0][BW-1:0] bnd;
  hole_code_t                hole;
  logic [N_ROWS-1:0]         sel;
  logic [BW-1:0]             start_units;
  logic                      found, in_hole, hit_d, take;
  logic [AW-1:0]             start_addr;

  row_bound_cfg #(.N_ROWS(N_ROWS), .BW(BW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .bnd(bnd), .hole(hole));

  row_bound_match #(.N_ROWS(N_ROWS), .BW(BW), .HI_W(HI_W)) u_match (
    .addr_hi(in_addr[AW-1:GL2]), .bnd(bnd), .sel(sel),
    .start_units(start_units), .found(found));

  row_bound_hole #(.AW(AW)) u_hole (.addr(in_addr), .code(hole), .in_hole(in_hole));

  assign hit_d      = found & ~in_hole;
  assign start_addr = AW'(start_units) << GL2;
  assign in_ready   = !res_valid || res_ready;
  assign take       = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_row    <= '0;
      res_offset <= '0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_row    <= hit_d ? sel : '0;
      res_offset <= hit_d ? (in_addr - start_addr) : '0;
      res_hit    <= hit_d;
      res_miss   <= ~hit_d;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_row)); // R3
  AST_HIT_HAS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_row != '0)); // R3
  AST_MISS_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> (res_row == '0 && res_offset == '0)); // R5
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit ^ res_miss)); // R9
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_row) &&
      $stable(res_offset) && $stable(res_hit) && $stable(res_miss))); // R10
endmodule

// File: tb/row_bound_decoder_test.sv
module row_bound_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [7:0]  res_row;
  logic [31:0] res_offset;
  logic        res_hit, res_miss;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] m_bnd [8];
  logic [1:0] m_hole = 2'b00;

  always #10 clk = ~clk;

  row_bound_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row),
    .res_offset(res_offset), .res_hit(res_hit), .res_miss(res_miss));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, output logic [7:0] row,
                                output logic [31:0] off, output logic hit);
    logic found = 1'b0;
    logic [7:0] prev = '0, start = '0;
    int r = 0;
    logic holed;
    holed = (m_hole == 2'b01 && a >= 32'h80000 && a < 32'hA0000) ||
            (m_hole == 2'b10 && a >= 32'hF00000 && a < 32'h1000000);
    for (int n = 0; n < 8; n++) begin
      if (!found && {1'b0, a[31:23]} < {2'b0, m_bnd[n]}) begin
        found = 1'b1; r = n; start = prev;
      end
      prev = m_bnd[n];
    end
    hit = found && !holed;
    row = hit ? (8'b1 << r) : 8'h0;
    off = hit ? (a - ({24'h0, start} << 23)) : 32'h0;
  endfunction

  task automatic cfg_write(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s < 8) m_bnd[s] = d; else if (s == 8) m_hole = d[1:0];
  endtask

  task automatic load_bounds(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    logic [7:0] v [8];
    v = '{b0, b1, b2, b3, b4, b5, b6, b7};
    for (int n = 0; n < 8; n++) cfg_write(4'(n), v[n]);
  endtask

  task automatic run_vec(input logic [31:0] a, input string tag);
    logic [7:0] er; logic [31:0] eo; logic eh;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(a, er, eo, eh);
    chk({tag, " R10 valid"}, 32'(res_valid), 32'd1);
    chk({tag, " row"}, 32'(res_row), 32'(er));
    chk({tag, " R9 offset"}, res_offset, eo);
    chk({tag, " R9 hit"}, {30'd0, res_hit, res_miss}, {30'd0, eh, ~eh});
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] er; logic [31:0] eo; logic eh;
    void'($urandom(32'd20240611));
    for (int n = 0; n < 8; n++) m_bnd[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
    run_vec(32'h0, "R1 zero bounds");
    chk("R1 miss", 32'(res_miss), 32'd1);

    // one 64 MB module in row 0
    load_bounds(8, 8, 8, 8, 8, 8, 8, 8);
    run_vec(32'h0, "R3 row0 start");
    run_vec(32'h03FF_FFFF, "R3 row0 last");
    run_vec(32'h0400_0000, "R5 top of memory");
    run_vec(32'hFFFF_FFFC, "R5 far above");

    // empty rows 1,3,4,6
    load_bounds(2, 2, 5, 5, 5, 9, 9, 12);
    run_vec(32'h0100_0000, "R4 skip empty row1");
    run_vec(32'h027F_FFFF, "R3 row2 last");
    run_vec(32'h0280_0000, "R4 skip rows3-4");
    run_vec(32'h0480_0000, "R4 skip row6");
    run_vec(32'h05FF_FFFF, "R3 row7 last");
    run_vec(32'h0600_0000, "R5 beyond row7");
    chk("R4 row bits", 32'(res_row), 32'd0);

    // holes
    load_bounds(8, 8, 8, 8, 8, 8, 8, 8);
    cfg_write(4'd8, 8'h01);
    run_vec(32'h0007_FFFF, "R6 below low hole");
    run_vec(32'h0008_0000, "R6 low hole start");
    run_vec(32'h0009_FFFF, "R6 low hole end");
    run_vec(32'h000A_0000, "R6 above low hole");
    run_vec(32'h00F0_0000, "R6 high range open");
    cfg_write(4'd8, 8'h02);
    run_vec(32'h00EF_FFFF, "R7 below high hole");
    run_vec(32'h00F0_0000, "R7 high hole start");
    run_vec(32'h00FF_FFFF, "R7 high hole end");
    run_vec(32'h0100_0000, "R7 above high hole");
    run_vec(32'h0008_0000, "R7 low range open");
    cfg_write(4'd8, 8'h03);
    run_vec(32'h0008_0000, "R8 code11 low");
    run_vec(32'h00F0_0000, "R8 code11 high");
    cfg_write(4'd8, 8'h00);
    run_vec(32'h0008_0000, "R8 code00 low");
    run_vec(32'h00F0_0000, "R8 code00 high");

    // R2: a new boundary applies to the next address
    cfg_write(4'd0, 8'h04);
    run_vec(32'h0200_0000, "R2 row0 shrunk");

    // R10 stall with a queued address
    @(negedge clk);
    res_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h0000_1234;
    @(negedge clk);
    in_addr = 32'h0300_0010;
    chk("R10 first result valid", 32'(res_valid), 32'd1);
    chk("R10 in_ready low in stall", 32'(in_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 stalled offset held", res_offset, 32'h0000_1234);
    chk("R10 stalled row held", 32'(res_row), 32'h01);
    res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(32'h0300_0010, er, eo, eh);
    chk("R10 queued row", 32'(res_row), 32'(er));
    chk("R10 queued offset", res_offset, eo);

    // constrained random
    for (int k = 0; k < 400; k++) begin
      if (k % 40 == 0) begin
        logic [8:0] acc = '0;
        for (int n = 0; n < 8; n++) begin
          if ($urandom % 4 != 0) acc = acc + 9'($urandom % 40);
          if (acc > 9'd255) acc = 9'd255;
          cfg_write(4'(n), acc[7:0]);
        end
        cfg_write(4'd8, 8'($urandom % 4));
      end
      begin
        logic [31:0] a;
        int pick = $urandom % 4;
        if (pick == 0)      a = 32'h7_0000 + ($urandom % 32'h4_0000);
        else if (pick == 1) a = 32'hE8_0000 + ($urandom % 32'h20_0000);
        else if (pick == 2) a = ({24'h0, m_bnd[$urandom % 8]} << 23) - 32'($urandom % 2);
        else                a = {9'($urandom % (32'(m_bnd[7]) + 2)), 23'($urandom)};
        run_vec(a, "R3 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule